// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer operand by another over several clock cycles, using a shift-and-trial-subtract loop that works out one quotient bit per cycle. A pulse on `start` while the unit is idle captures both operands and the signedness select. The unit then stays busy for as many cycles as the operand width. In the cycle it goes idle, it raises `done` for one cycle and shows the quotient on `lo` and the remainder on `hi`. Both result outputs hold their values until the next division completes.

In unsigned mode the operands are plain binary magnitudes. In signed mode they are two's complement. The loop runs on magnitudes and a final correction step applies the signs: the quotient rounds toward zero and the remainder carries the dividend's sign. A zero divisor and a quotient that does not fit are not detected. Both give a fixed, well-defined pattern and raise no flag.

Top module: `seq_restoring_divider`

## Requirements
- R1: Unsigned mode (`signed_mode`=0): when the divisor is nonzero, `lo` = floor(dividend / divisor) and `hi` = dividend mod divisor. Together these satisfy dividend = lo*divisor + hi, with hi < divisor.
- R2: Signed mode (`signed_mode`=1, two's complement): the quotient magnitude is |dividend| / |divisor| rounded down, and it is negated when the operand sign bits differ. The remainder magnitude is |dividend| mod |divisor|, and it is negated when the dividend is negative. For example, -7/2 gives lo=-3 and hi=-1.
- R3: Unsigned mode with a zero divisor completes in the normal time and gives `lo` = all ones and `hi` = dividend.
- R4: Signed mode with a zero divisor completes in the normal time and gives `hi` = dividend. `lo` is all ones when the dividend is non-negative and 1 when it is negative.
- R5: In signed mode, the most negative value divided by -1 gives `lo` = 0x80000000 and `hi` = 0, and nothing is flagged.
- R6: A `start` sampled high while `busy` is low makes `busy` high from the next cycle on, for exactly WIDTH cycles.
- R7: `done` is high for exactly one cycle, in the first cycle after the last busy cycle. `hi`/`lo` take their new values in that same cycle and hold them until the next `done`.
- R8: A `start` sampled while `busy` is high is ignored. The running division finishes with the operands captured first.
- R9: After synchronous reset, `busy`, `done`, `hi` and `lo` are all 0.
- R10: A `start` sampled in the cycle where `done` is high is accepted, so divisions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, sampled with start |
| divisor | input | WIDTH | Divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | WIDTH | Remainder of the last division |
| lo | output | WIDTH | Quotient of the last division |

## Verification
The bench builds the block with WIDTH left at its default of 32. This makes the exact full-width corner cases reachable: an all-ones dividend, the most negative value divided by -1, and zero divisors in both modes. Because the width is full size, the 32-cycle busy window can be checked against a count in the reference model. A behavioural model computes each result with integer division on magnitudes, and every cycle the bench compares `busy`, `done`, `hi` and `lo` with that model. The stimulus also covers a start that arrives mid-run and a start issued during the done cycle.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    function automatic int step_cnt_w(input int width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] num,
    input  logic [WIDTH-1:0] den,
    input  logic             is_signed,
    output logic [WIDTH-1:0] num_mag,
    output logic [WIDTH-1:0] den_mag,
    output logic             flip_quo,
    output logic             flip_rem
);
    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg  = is_signed & num[WIDTH-1];
        den_neg  = is_signed & den[WIDTH-1];
        num_mag  = num_neg ? (~num + 1'b1) : num;
        den_mag  = den_neg ? (~den + 1'b1) : den;
        flip_quo = num_neg ^ den_neg;
        flip_rem = num_neg;
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] part_in,
    input  logic [WIDTH-1:0] quo_in,
    input  logic [WIDTH-1:0] den_in,
    output logic [WIDTH-1:0] part_out,
    output logic [WIDTH-1:0] quo_out
);
    logic [WIDTH:0]   shifted;
    logic [WIDTH-1:0] trial;
    logic             fits;

    always_comb begin
        // bring the next dividend bit into the partial remainder
        shifted  = {part_in, quo_in[WIDTH-1]};
        // true difference is below 2^WIDTH whenever it is kept
        trial    = shifted[WIDTH-1:0] - den_in;
        fits     = shifted >= {1'b0, den_in};
        part_out = fits ? trial : shifted[WIDTH-1:0];
        quo_out  = {quo_in[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] quo_mag,
    input  logic [WIDTH-1:0] rem_mag,
    input  logic             flip_quo,
    input  logic             flip_rem,
    output logic [WIDTH-1:0] quo,
    output logic [WIDTH-1:0] rem
);
    always_comb begin
        quo = flip_quo ? (~quo_mag + 1'b1) : quo_mag;
        rem = flip_rem ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    localparam int CW = step_cnt_w(WIDTH);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    div_state_e       state_q;
    logic [CW-1:0]    step_q;
    logic [WIDTH-1:0] part_q, quo_q, den_q;
    logic             flipq_q, flipr_q;

    logic [WIDTH-1:0] num_mag, den_mag;
    logic             flip_quo, flip_rem;
    logic [WIDTH-1:0] part_nx, quo_nx;
    logic [WIDTH-1:0] quo_fixed, rem_fixed;
    logic             accept;

    assign busy   = (state_q == DIV_RUN);
    assign accept = start && !busy;

    div_sign_prep #(.WIDTH(WIDTH)) u_prep (
        .num(dividend), .den(divisor), .is_signed(signed_mode),
        .num_mag(num_mag), .den_mag(den_mag),
        .flip_quo(flip_quo), .flip_rem(flip_rem)
    );

    div_step #(.WIDTH(WIDTH)) u_step (
        .part_in(part_q), .quo_in(quo_q), .den_in(den_q),
        .part_out(part_nx), .quo_out(quo_nx)
    );

    div_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .quo_mag(quo_nx), .rem_mag(part_nx),
        .flip_quo(flipq_q), .flip_rem(flipr_q),
        .quo(quo_fixed), .rem(rem_fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            step_q  <= '0;
            part_q  <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            flipq_q <= 1'b0;
            flipr_q <= 1'b0;
            done    <= 1'b0;
            hi      <= '0;
            lo      <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state_q <= DIV_RUN;
                step_q  <= '0;
                part_q  <= '0;
                quo_q   <= num_mag;
                den_q   <= den_mag;
                flipq_q <= flip_quo;
                flipr_q <= flip_rem;
            end else if (busy) begin
                part_q <= part_nx;
                quo_q  <= quo_nx;
                if (step_q == LAST_STEP) begin
                    state_q <= DIV_IDLE;
                    done    <= 1'b1;
                    hi      <= rem_fixed;
                    lo      <= quo_fixed;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // busy-cycle counter used only by the length check below
    logic [CW:0] chk_len_q;
    always_ff @(posedge clk) begin
        if (rst || accept) chk_len_q <= '0;
        else if (busy)     chk_len_q <= chk_len_q + 1'b1;
    end

    a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        done |-> (chk_len_q == (CW+1)'(WIDTH)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r7_results_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(hi) && $stable(lo)));

    a_r8_divisor_held: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(den_q));

    a_r1_partial_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (busy && den_q != '0) |-> (part_q < den_q));

endmodule

// File: tb/sim_seq_restoring_divider.sv
`timescale 1ns/1ps
module sim_seq_restoring_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R9";
    bit started = 0;

    always #4 clk = ~clk;

    seq_restoring_divider #(.WIDTH(32)) u0 (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    // behavioural reference result: {remainder, quotient}
    function automatic logic [63:0] ref_div(input logic [31:0] a, input logic [31:0] b,
                                            input logic s);
        logic [31:0] ua, ub, uq, ur;
        ua = (s && a[31]) ? (32'd0 - a) : a;
        ub = (s && b[31]) ? (32'd0 - b) : b;
        if (ub == 0) begin uq = 32'hFFFF_FFFF; ur = ua; end
        else begin uq = ua / ub; ur = ua % ub; end
        if (s && (a[31] ^ b[31])) uq = 32'd0 - uq;
        if (s && a[31]) ur = 32'd0 - ur;
        return {ur, uq};
    endfunction

    // cycle model
    logic        m_busy = 0, m_done = 0;
    logic [31:0] m_hi = 0, m_lo = 0, p_hi = 0, p_lo = 0;
    int          m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_hi <= 0; m_lo <= 0; m_cnt <= 0;
        end else begin
            m_done <= 0;
            if (!m_busy && start) begin
                m_busy <= 1; m_cnt <= 0;
                {p_hi, p_lo} <= ref_div(dividend, divisor, signed_mode);
            end else if (m_busy) begin
                if (m_cnt == 31) begin
                    m_busy <= 0; m_done <= 1; m_hi <= p_hi; m_lo <= p_lo;
                end else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    initial begin
        @(posedge clk);
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            check({"R6 busy (", cur_req, ")"}, {31'd0, busy}, {31'd0, m_busy});
            check({"R7 done (", cur_req, ")"}, {31'd0, done}, {31'd0, m_done});
            check({cur_req, " hi"}, hi, m_hi);
            check({cur_req, " lo"}, lo, m_lo);
        end
    end

    // caller is at a negedge; start is seen at the next posedge
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s);
        #1;
        dividend = a; divisor = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (m_done) break;
        end
    endtask

    task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic s);
        cur_req = req;
        issue(a, b, s);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R9";
        check("R9 reset hi", hi, 32'd0);
        check("R9 reset lo", lo, 32'd0);
        check("R9 reset busy", {31'd0, busy}, 32'd0);
        #1 rst = 1'b0;
        @(negedge clk);

        run("R1", 32'd147, 32'd11, 1'b0);
        check("R1 147/11 quotient", lo, 32'd13);
        check("R1 147/11 remainder", hi, 32'd4);
        run("R1", 32'd5, 32'd7, 1'b0);
        run("R1", 32'hFFFF_FFFF, 32'd1, 1'b0);
        run("R1", 32'hFFFF_FFFF, 32'h8000_0000, 1'b0);
        run("R2", -32'sd7, 32'd2, 1'b1);
        check("R2 -7/2 quotient", lo, -32'sd3);
        check("R2 -7/2 remainder", hi, -32'sd1);
        run("R2", 32'd7, -32'sd2, 1'b1);
        run("R2", -32'sd7, -32'sd2, 1'b1);
        run("R2", 32'h8000_0000, 32'd3, 1'b0);
        run("R3", 32'h1234_5678, 32'd0, 1'b0);
        check("R3 zero divisor quotient", lo, 32'hFFFF_FFFF);
        run("R4", -32'sd5, 32'd0, 1'b1);
        check("R4 negative over zero quotient", lo, 32'd1);
        run("R4", 32'd5, 32'd0, 1'b1);
        run("R5", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        check("R5 overflow quotient", lo, 32'h8000_0000);
        check("R5 overflow remainder", hi, 32'd0);

        // R8: a start mid-run with other operands is ignored
        cur_req = "R8";
        issue(32'd100, 32'd9, 1'b0);
        repeat (5) @(negedge clk);
        issue(32'd1, 32'd1, 1'b1);
        wait_done();
        check("R8 ignored start quotient", lo, 32'd11);
        check("R8 ignored start remainder", hi, 32'd1);

        // R10: start during the done cycle
        cur_req = "R10";
        issue(32'd50, 32'd7, 1'b0);
        wait_done();
        issue(32'd81, 32'd9, 1'b0);
        check("R10 busy after back-to-back start", {31'd0, busy}, 32'd1);
        wait_done();
        check("R10 second quotient", lo, 32'd9);

        for (int k = 0; k < 24; k++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (k % 3 == 0) ? ($urandom & 32'h0000_00FF) : $urandom;
            run((k % 2) ? "R2" : "R1", a, b, 1'(k % 2));
        end

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL R6 watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule